// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits on the controller side of an SDRAM interface and walks the device into self-refresh and back out again when a power manager asks. On an accepted enter request it drives a single self-refresh entry command: chip select, row strobe and column strobe low, write enable high, and the clock-enable pin low. It then holds a run of deselect cycles with clock enable still low, so that the device is given only no-op traffic right after entry. Clock enable stays low for as long as the device rests in self-refresh. While the device is in that state it ignores every control pin except clock enable.

Leaving self-refresh begins when the power manager raises an exit request. The request is honoured only after the post-entry guard has run out and while the clock-stable input reports a running clock. The sequencer then raises clock enable and holds it high with chip select deasserted for a long exit interval, 20001 cycles by default. This keeps the wait strictly above 20000 clocks. At the end it returns to idle and pulses a resume strobe for one cycle, so the command scheduler knows that normal traffic may restart. A ready output is low through the whole excursion. The guard length and the exit length are parameters counted in clock cycles.

Top module: `srf_seq`

## Requirements
- R1: After reset, cke is 1, csN, rasN, casN and weN are all 1 (deselect), ready is 1 and resumePulse is 0.
- R2: When enterReq and banksIdle are both 1 in the idle state at a clock edge, the next cycle shows the entry command: cke=0, csN=0, rasN=0, casN=0, weN=1. The command lasts exactly one cycle.
- R3: An enterReq that arrives while banksIdle is 0 leaves the block idle, with cke=1, csN=1 and ready=1. The entry command follows in the cycle after banksIdle becomes 1, provided enterReq is still held.
- R4: After the entry command, at least GUARD_CYCLES cycles of deselect (csN=1) with cke=0 follow. An exitReq raised during these cycles does not shorten them.
- R5: Clock enable stays 0 from the entry command until an exit request has been accepted.
- R6: An exitReq is accepted only while clkStable is 1. While clkStable is 0, cke stays 0 however long exitReq is held.
- R7: In the cycle after an exit request is accepted, cke goes to 1. It then stays 1 with csN=1 for exactly EXIT_CYCLES cycles, 20001 by default.
- R8: ready is 0 from the entry command through the last exit-wait cycle, and is 1 in every other cycle.
- R9: resumePulse is 1 for exactly one cycle: the first cycle after the exit wait, when ready is 1 again.
- R10: An enterReq raised while the block is not idle has no effect. The exit wait keeps its full length and no entry command is issued.
- R11: csN is 0 only in the entry-command cycle. No other command is ever driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| enterReq | input | 1 | Power manager asks for self-refresh |
| exitReq | input | 1 | Power manager asks to leave self-refresh |
| banksIdle | input | 1 | All banks precharged and idle for the required time |
| clkStable | input | 1 | Device clock is running and stable |
| cke | output | 1 | Clock enable to the device |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ready | output | 1 | High when the device is out of self-refresh and usable |
| resumePulse | output | 1 | One-cycle strobe: normal commands may restart |

## Verification
The assertions rely on the power manager raising enterReq only once banksIdle already covers the precharge wait. They also assume that exitReq is raised only after the clock has actually restarted, which clkStable reports. The stimulus keeps to this by changing inputs only at falling edges and by holding clkStable low during the stretch that stands for a stopped clock. It also raises enterReq during the exit wait only to show that the request is ignored, and drops it before the block returns to idle. Because the default exit length is used unchanged, the cycle counts in the bench match the values a real device needs.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [2:0] {
    SRF_IDLE      = 3'd0,
    SRF_ENTER     = 3'd1,
    SRF_GUARD     = 3'd2,
    SRF_IN_SR     = 3'd3,
    SRF_EXIT_WAIT = 3'd4
  } srf_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic issueEntry;  // drive the self-refresh entry command this cycle
    logic ckeLow;      // hold clock enable low
    logic busy;        // sequence in progress, ready deasserted
    logic loadGuard;   // start the post-entry guard count
    logic loadExit;    // start the exit-wait count
    logic finish;      // last exit-wait cycle
  } srf_strobe_t;

endpackage

// File: rtl/srf_ctrl.sv
module srf_ctrl
  import srf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enterReq,
  input  logic        exitReq,
  input  logic        banksIdle,
  input  logic        clkStable,
  input  logic        cntZero,
  output srf_strobe_t strobe
);

  srf_state_e state, stateNext;
  logic exitGo;

  assign exitGo = (state == SRF_IN_SR) && exitReq && clkStable;

  always_comb begin
    stateNext = state;
    unique case (state)
      SRF_IDLE:      if (enterReq && banksIdle) stateNext = SRF_ENTER;
      SRF_ENTER:     stateNext = SRF_GUARD;
      SRF_GUARD:     if (cntZero) stateNext = SRF_IN_SR;
      SRF_IN_SR:     if (exitGo) stateNext = SRF_EXIT_WAIT;
      SRF_EXIT_WAIT: if (cntZero) stateNext = SRF_IDLE;
      default:       stateNext = SRF_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SRF_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.issueEntry = (state == SRF_ENTER);
    strobe.ckeLow     = (state == SRF_ENTER) || (state == SRF_GUARD) || (state == SRF_IN_SR);
    strobe.busy       = (state != SRF_IDLE);
    strobe.loadGuard  = (state == SRF_ENTER);
    strobe.loadExit   = exitGo;
    strobe.finish     = (state == SRF_EXIT_WAIT) && cntZero;
  end

  // R3: no entry while banks are busy
  p_wait_banks_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRF_IDLE && enterReq && !banksIdle) |=> (state == SRF_IDLE));

  // R6: exit refused without a stable clock
  p_exit_needs_clk_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRF_IN_SR && !clkStable) |=> (state == SRF_IN_SR));

  // R10: enter request ignored outside idle
  p_enter_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == SRF_EXIT_WAIT && !cntZero) |=> (state == SRF_EXIT_WAIT));

endmodule

// File: rtl/srf_datapath.sv
module srf_datapath
  import srf_pkg::*;
#(
  parameter int GUARD_CYCLES = 4,
  parameter int EXIT_CYCLES  = 20001,
  parameter int CNT_W        = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  srf_strobe_t strobe,
  output logic        cntZero,
  output logic        cke,
  output logic        csN,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        ready,
  output logic        resumePulse
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (strobe.loadGuard) cnt <= CNT_W'(GUARD_CYCLES - 1);
    else if (strobe.loadExit)  cnt <= CNT_W'(EXIT_CYCLES - 1);
    else if (cnt != '0)        cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) resumePulse <= 1'b0;
    else       resumePulse <= strobe.finish;
  end

  assign cke   = !strobe.ckeLow;
  assign csN   = !strobe.issueEntry;
  assign rasN  = !strobe.issueEntry;
  assign casN  = !strobe.issueEntry;
  assign weN   = 1'b1;
  assign ready = !strobe.busy;

  // checker state: cycles with cke low since the last entry command
  logic [CNT_W-1:0] sinceEntry;
  // checker state: cycles with cke high while not ready
  logic [CNT_W-1:0] waitSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceEntry <= '0;
      waitSeen   <= '0;
    end else begin
      if (!csN) sinceEntry <= '0;
      else if (!cke && sinceEntry != CNT_W'(GUARD_CYCLES)) sinceEntry <= sinceEntry + 1'b1;
      if (ready) waitSeen <= '0;
      else if (cke && waitSeen != CNT_W'(EXIT_CYCLES)) waitSeen <= waitSeen + 1'b1;
    end
  end

  // R2: entry command lasts one cycle
  p_entry_one_cycle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!csN) |=> csN);

  // R4: guard completed before cke rises
  p_guard_min_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> (sinceEntry == CNT_W'(GUARD_CYCLES)));

  // R5: cke falls only with the entry command
  p_cke_fall_entry_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cke) |-> (!csN && !rasN && !casN && weN));

  // R7: full exit wait before ready returns
  p_exit_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> (waitSeen == CNT_W'(EXIT_CYCLES)));

  // R8: never ready while cke is low
  p_not_ready_sr_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!cke) |-> (!ready));

  // R9: resume is single and coincides with ready
  p_resume_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> (ready && $rose(ready)));

  // R11: chip select only with the entry pattern
  p_cs_only_entry_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!csN) |-> (!rasN && !casN && weN && !cke));

endmodule

// File: rtl/srf_seq.sv
module srf_seq
  import srf_pkg::*;
#(
  parameter int GUARD_CYCLES = 4,
  parameter int EXIT_CYCLES  = 20001
) (
  input  logic clk,
  input  logic rstN,
  input  logic enterReq,
  input  logic exitReq,
  input  logic banksIdle,
  input  logic clkStable,
  output logic cke,
  output logic csN,
  output logic rasN,
  output logic casN,
  output logic weN,
  output logic ready,
  output logic resumePulse
);

  localparam int MAX_CNT = (EXIT_CYCLES > GUARD_CYCLES) ? EXIT_CYCLES : GUARD_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1) + 1;

  srf_strobe_t strobe;
  logic        cntZero;

  srf_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enterReq  (enterReq),
    .exitReq   (exitReq),
    .banksIdle (banksIdle),
    .clkStable (clkStable),
    .cntZero   (cntZero),
    .strobe    (strobe)
  );

  srf_datapath #(
    .GUARD_CYCLES (GUARD_CYCLES),
    .EXIT_CYCLES  (EXIT_CYCLES),
    .CNT_W        (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .cntZero     (cntZero),
    .cke         (cke),
    .csN         (csN),
    .rasN        (rasN),
    .casN        (casN),
    .weN         (weN),
    .ready       (ready),
    .resumePulse (resumePulse)
  );

endmodule

// File: tb/test_srf_seq.sv
module test_srf_seq;

  localparam int GUARD = 4;
  localparam int EXITN = 20001;

  logic clk = 1'b0;
  logic rstN, enterReq, exitReq, banksIdle, clkStable;
  logic cke, csN, rasN, casN, weN, ready, resumePulse;

  int nRun = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  srf_seq #(.GUARD_CYCLES(GUARD), .EXIT_CYCLES(EXITN)) i_srf_seq (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .exitReq(exitReq),
    .banksIdle(banksIdle), .clkStable(clkStable), .cke(cke), .csN(csN),
    .rasN(rasN), .casN(casN), .weN(weN), .ready(ready), .resumePulse(resumePulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pins();
    return {cke, csN, rasN, casN, weN};
  endfunction

  task automatic tReset();
    rstN = 1'b0; enterReq = 0; exitReq = 0; banksIdle = 0; clkStable = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(pins() == 5'b11111, "R1 pins", pins(), 5'b11111);
    chk(ready && !resumePulse, "R1 ready/resume", {ready, resumePulse}, 2'b10);
  endtask

  // enter with banks busy, then released; exit request held through guard
  task automatic tEnterGuard();
    bit ok;
    enterReq = 1; banksIdle = 0;
    ok = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!(cke && csN && ready)) ok = 0;
    end
    chk(ok, "R3 wait banks", {cke, csN, ready}, 3'b111);
    banksIdle = 1;
    @(negedge clk);
    chk(pins() == 5'b00001, "R2 entry command", pins(), 5'b00001);
    chk(!ready, "R8 ready low at entry", ready, 0);
    enterReq = 0; exitReq = 1; clkStable = 1;
    ok = 1;
    for (int i = 0; i < GUARD; i++) begin
      @(negedge clk);
      if (!(cke == 0 && csN == 1)) ok = 0;
    end
    chk(ok, "R4 guard deselect, cke low", {cke, csN}, 2'b01);
    @(negedge clk);
    chk(cke == 0, "R4 exit not taken inside guard", cke, 0);
    exitReq = 0;
  endtask

  // exit refused without stable clock, then accepted; count the wait
  task automatic tExit(input bit stallClk, input bit pokeEnter);
    int cnt;
    bit ok;
    if (stallClk) begin
      clkStable = 0; exitReq = 1;
      ok = 1;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (cke || ready) ok = 0;
      end
      chk(ok, "R6 no exit without clkStable", cke, 0);
      chk(cke == 0, "R5 cke held low", cke, 0);
    end
    clkStable = 1; exitReq = 1;
    @(negedge clk);
    exitReq = 0;
    chk(cke == 1, "R7 cke rises after accept", cke, 1);
    cnt = 0; ok = 1;
    while (!ready && cnt < 30000) begin
      if (!(cke && csN)) ok = 0;
      if (pokeEnter) enterReq = (cnt > 10 && cnt < 200);
      cnt++;
      @(negedge clk);
    end
    enterReq = 0;
    chk(ok, "R11 deselect with cke high during wait", {cke, csN}, 2'b11);
    chk(cnt == EXITN, "R7 exit wait length", cnt, EXITN);
    chk(ready && resumePulse, "R9 resume at ready", {ready, resumePulse}, 2'b11);
    @(negedge clk);
    chk(!resumePulse && ready, "R9 resume single cycle", resumePulse, 0);
    if (pokeEnter) chk(pins() == 5'b11111, "R10 no entry from ignored request", pins(), 5'b11111);
  endtask

  task automatic tDirect();
    bit ok;
    enterReq = 1; banksIdle = 1;
    @(negedge clk);
    enterReq = 0;
    chk(pins() == 5'b00001, "R2 direct entry", pins(), 5'b00001);
    @(negedge clk);
    chk(csN && !cke, "R2 entry one cycle", {csN, cke}, 2'b10);
    ok = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cke || !csN || ready) ok = 0;
    end
    chk(ok, "R5 cke stays low in self-refresh", cke, 0);
  endtask

  initial begin
    tReset();
    tEnterGuard();
    tExit(1'b1, 1'b1);
    tDirect();
    tExit(1'b0, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule